// File: doc/BRIEF.md
# SPI Register Port

This block is a serial slave that lets software read and write a small bank of control and status registers over a four-wire SPI link in mode 3: the clock idles high, the slave launches data on falling clock edges and the master samples on rising edges. All link inputs are brought into the system clock domain through a synchronizer. Edges of the serial clock are then detected against `clk`, so the serial clock has to be much slower than the system clock.

Every access is a frame of exactly three bytes, sent MSB first while the active-low select is held low. The first input byte has a two-bit operation code and a six-bit register address. The slave always answers one byte late. It sends a zero byte, then the command byte it received, then either the written byte or the register contents. The register bank holds these items:

- per-channel receive and transmit enable bits, which are also driven out as ports
- a four-byte scratch area
- read-only views of per-channel signal strength and of temperature
- a transmit fault register with live bits and latched bits, where the latched bits are cleared by a read

Top module: `spi_regport`

## Requirements
- R1: A frame starts when `spi_cs_n` goes low and holds 24 bits, MSB first. Input byte 1 has the opcode in bits 7:6 and the register address in bits 5:0. Opcode 2'b00 (0x00) writes, 2'b01 (0x40) reads.
- R2: A write stores input byte 2 into the addressed writable register. A read returns the addressed register as output byte 3. The enable ports change only as a result of a write.
- R3: Output byte 1 is 0x00 and output byte 2 echoes input byte 1. Output byte 3 is the register value for a read; for every other opcode it echoes input byte 2.
- R4: Opcodes 2'b10 (0x80) and 2'b11 (0xC0) change no register and no port.
- R5: While `spi_cs_n` is high, `spi_miso_oe` is low, and clock or data toggling has no effect on any register.
- R6: After the 24th bit, `spi_miso` keeps the last bit until `spi_cs_n` rises. Extra clock edges in that frame are ignored.
- R7: Receive enable (address 0x25) and transmit enable (address 0x34) are N_CH-bit registers that reset to all ones. They read back zero-extended, and `rx_chan_en`/`tx_chan_en` show their values.
- R8: Addresses 0x14 to 0x17 are four independent 8-bit read/write scratch bytes that reset to 0.
- R9: Addresses 0x20 to 0x23 read the signal strength of channels 0 to 3 (`rssi_in` byte i is channel i), and 0x24 reads `temp_in`. Writes to these or to undefined addresses are discarded, and undefined addresses read 0x00.
- R10: Fault register 0x36: bits 3:0 are the live faults `tx_fault_in & tx_chan_en`. Bits 7:4 latch any live fault seen since they were last cleared.
- R11: A read of 0x36 clears only the latched bits it reported, and only after the 24th bit has been sampled. A fault that is live when the clear happens, or that appears after the read captured its value, stays latched.
- R12: Input bits are taken on rising serial-clock edges, and output bits change on falling edges, so the master can sample `spi_miso` just before each rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idles high |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | Output enable for the `spi_miso` pad driver |
| rssi_in | input | N_CH*8 | Signal strength per channel, channel i in byte i |
| temp_in | input | 8 | Temperature reading |
| tx_fault_in | input | N_CH | Live transmit fault per channel |
| rx_chan_en | output | N_CH | Receive enable register |
| tx_chan_en | output | N_CH | Transmit enable register |

## Verification
The frames sent cover writes, reads, both no-op opcodes, writes to read-only and unmapped addresses, clocking while deselected, and frames with surplus clocks after the 24th bit. Together they separate the three possible third-byte sources (register data, echoed data, and nothing stored) and separate a real frame from ignored bus activity. Fault stimulus is timed in four ways: a pulse before a read, a fault held through a read, a fault on a disabled channel, and a pulse after the read has captured its value. These show whether the clear is masked, lost to a same-time fault, or wrongly applied to bits that were never reported.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
   localparam int BYTE_W      = 8;
   localparam int OP_W        = 2;
   localparam int ADDR_W      = BYTE_W - OP_W;
   localparam int FRAME_BYTES = 3;
   localparam int FRAME_BITS  = FRAME_BYTES * BYTE_W;
   localparam int CNT_W       = $clog2(FRAME_BITS + 1);
   localparam int IDX_W       = $clog2(BYTE_W);
   localparam int BIDX_W      = CNT_W - IDX_W;

   typedef enum logic [OP_W-1:0] {
      OP_WRITE   = 2'b00,
      OP_READ    = 2'b01,
      OP_NOP_A   = 2'b10,
      OP_NOP_B   = 2'b11
   } op_e;
endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
   parameter int               WIDTH   = 3,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   initial begin
      if (STAGES < 2 || STAGES > 8) $fatal(1, "sync depth out of range");
   end

   logic [WIDTH-1:0] stg [STAGES];

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      stg[g] <= RST_VAL;
            else if (g == 0) stg[g] <= d;
            else             stg[g] <= stg[(g == 0) ? 0 : g-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_regport_engine.sv
module spi_regport_engine
   import spi_regport_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              sclk_rise,
   input  logic              sclk_fall,
   input  logic              sdi,
   input  logic [BYTE_W-1:0] rd_data,
   output logic [ADDR_W-1:0] addr,
   output logic              wr_stb,
   output logic [BYTE_W-1:0] wr_data,
   output logic              cap_stb,
   output logic              clr_stb,
   output logic              sdo,
   output logic [CNT_W-1:0]  in_cnt,
   output logic [CNT_W-1:0]  out_cnt
);
   localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(BYTE_W - 1);
   localparam logic [CNT_W-1:0] DAT_LAST  = CNT_W'(2*BYTE_W - 1);
   localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(FRAME_BITS - 1);
   localparam logic [CNT_W-1:0] FRAME_END = CNT_W'(FRAME_BITS);

   logic [BYTE_W-1:0] rx_sh, rx_next, cmd_q, dat_q, rd_q, tx_sh, nxt_byte;
   logic              sdo_q, cap_q, wr_q, clr_q;
   op_e               op;

   assign op      = op_e'(cmd_q[BYTE_W-1 -: OP_W]);
   assign rx_next = {rx_sh[BYTE_W-2:0], sdi};

   // byte launched at the start of each output byte slot
   always_comb begin
      case (out_cnt[CNT_W-1:IDX_W])
         BIDX_W'(0): nxt_byte = '0;
         BIDX_W'(1): nxt_byte = cmd_q;
         default:    nxt_byte = (op == OP_READ) ? rd_q : dat_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_cnt <= '0; out_cnt <= '0; rx_sh <= '0; cmd_q <= '0; dat_q <= '0;
         rd_q <= '0; tx_sh <= '0; sdo_q <= 1'b0;
         cap_q <= 1'b0; wr_q <= 1'b0; clr_q <= 1'b0;
      end else begin
         cap_q <= 1'b0;
         wr_q  <= 1'b0;
         clr_q <= 1'b0;
         if (!active) begin
            in_cnt <= '0; out_cnt <= '0; sdo_q <= 1'b0; cmd_q <= '0;
         end else begin
            if (cap_q) rd_q <= rd_data;
            if (sclk_rise && in_cnt != FRAME_END) begin
               rx_sh  <= rx_next;
               in_cnt <= in_cnt + 1'b1;
               if (in_cnt == CMD_LAST) begin
                  cmd_q <= rx_next;
                  cap_q <= 1'b1;
               end
               if (in_cnt == DAT_LAST) begin
                  dat_q <= rx_next;
                  wr_q  <= (op == OP_WRITE);
               end
               if (in_cnt == BIT_LAST) clr_q <= (op == OP_READ);
            end
            if (sclk_fall && out_cnt != FRAME_END) begin
               out_cnt <= out_cnt + 1'b1;
               if (out_cnt[IDX_W-1:0] == '0) begin
                  sdo_q <= nxt_byte[BYTE_W-1];
                  tx_sh <= {nxt_byte[BYTE_W-2:0], 1'b0};
               end else begin
                  sdo_q <= tx_sh[BYTE_W-1];
                  tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
               end
            end
         end
      end
   end

   assign addr    = cmd_q[ADDR_W-1:0];
   assign wr_stb  = wr_q;
   assign wr_data = dat_q;
   assign cap_stb = cap_q;
   assign clr_stb = clr_q;
   assign sdo     = sdo_q;
endmodule

// File: rtl/spi_regport_regs.sv
module spi_regport_regs
   import spi_regport_pkg::*;
#(
   parameter int N_CH       = 4,
   parameter int SCR_BYTES  = 4,
   parameter int SCR_BASE   = 'h14,
   parameter int RSSI_BASE  = 'h20,
   parameter int TEMP_ADDR  = 'h24,
   parameter int RXEN_ADDR  = 'h25,
   parameter int TXEN_ADDR  = 'h34,
   parameter int FAULT_ADDR = 'h36
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [ADDR_W-1:0]      addr,
   input  logic                   wr_stb,
   input  logic [BYTE_W-1:0]      wr_data,
   input  logic                   cap_stb,
   input  logic                   clr_stb,
   input  logic [N_CH*BYTE_W-1:0] rssi_in,
   input  logic [BYTE_W-1:0]      temp_in,
   input  logic [N_CH-1:0]        fault_in,
   output logic [BYTE_W-1:0]      rd_data,
   output logic [N_CH-1:0]        rx_en,
   output logic [N_CH-1:0]        tx_en,
   output logic [N_CH-1:0]        fault_lat
);
   localparam int HALF = BYTE_W / 2;
   localparam int AMAX = 1 << ADDR_W;

   initial begin
      if (N_CH < 1 || N_CH > HALF) $fatal(1, "channel count out of range");
      if (SCR_BASE + SCR_BYTES > AMAX || RSSI_BASE + N_CH > AMAX ||
          TEMP_ADDR >= AMAX || RXEN_ADDR >= AMAX || TXEN_ADDR >= AMAX ||
          FAULT_ADDR >= AMAX) $fatal(1, "register address out of range");
   end

   logic [BYTE_W-1:0] scr [SCR_BYTES];
   logic [N_CH-1:0]   live, snap, clr_bits;
   logic              hit_fault;

   assign hit_fault = (addr == ADDR_W'(FAULT_ADDR));
   assign live      = fault_in & tx_en;
   assign clr_bits  = (clr_stb && hit_fault) ? snap : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_en     <= '1;
         tx_en     <= '1;
         fault_lat <= '0;
         snap      <= '0;
         for (int i = 0; i < SCR_BYTES; i++) scr[i] <= '0;
      end else begin
         // a fault live in the clearing cycle re-sets its bit
         fault_lat <= (fault_lat & ~clr_bits) | live;
         if (cap_stb && hit_fault) snap <= fault_lat;
         if (wr_stb) begin
            if (addr == ADDR_W'(RXEN_ADDR)) rx_en <= wr_data[N_CH-1:0];
            if (addr == ADDR_W'(TXEN_ADDR)) tx_en <= wr_data[N_CH-1:0];
            for (int i = 0; i < SCR_BYTES; i++)
               if (addr == ADDR_W'(SCR_BASE + i)) scr[i] <= wr_data;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < SCR_BYTES; i++)
         if (addr == ADDR_W'(SCR_BASE + i)) rd_data = scr[i];
      for (int i = 0; i < N_CH; i++)
         if (addr == ADDR_W'(RSSI_BASE + i)) rd_data = rssi_in[i*BYTE_W +: BYTE_W];
      if (addr == ADDR_W'(TEMP_ADDR)) rd_data = temp_in;
      if (addr == ADDR_W'(RXEN_ADDR)) rd_data = BYTE_W'(rx_en);
      if (addr == ADDR_W'(TXEN_ADDR)) rd_data = BYTE_W'(tx_en);
      if (hit_fault)                  rd_data = {HALF'(fault_lat), HALF'(live)};
   end
endmodule

// File: rtl/spi_regport.sv
module spi_regport
   import spi_regport_pkg::*;
#(
   parameter int N_CH        = 4,
   parameter int SYNC_STAGES = 2,
   parameter int SCR_BYTES   = 4,
   parameter int SCR_BASE    = 'h14,
   parameter int RSSI_BASE   = 'h20,
   parameter int TEMP_ADDR   = 'h24,
   parameter int RXEN_ADDR   = 'h25,
   parameter int TXEN_ADDR   = 'h34,
   parameter int FAULT_ADDR  = 'h36
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   spi_sclk,
   input  logic                   spi_cs_n,
   input  logic                   spi_mosi,
   output logic                   spi_miso,
   output logic                   spi_miso_oe,
   input  logic [N_CH*BYTE_W-1:0] rssi_in,
   input  logic [BYTE_W-1:0]      temp_in,
   input  logic [N_CH-1:0]        tx_fault_in,
   output logic [N_CH-1:0]        rx_chan_en,
   output logic [N_CH-1:0]        tx_chan_en
);
   logic              sclk_s, cs_s, mosi_s, sclk_d, active, rise, fall;
   logic [ADDR_W-1:0] addr;
   logic [BYTE_W-1:0] wr_data, rd_data;
   logic              wr_stb, cap_stb, clr_stb, sdo;
   logic [CNT_W-1:0]  in_cnt, out_cnt;
   logic [N_CH-1:0]   fault_lat;

   spi_regport_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({spi_sclk, spi_cs_n, spi_mosi}),
      .q({sclk_s, cs_s, mosi_s})
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b1;
      else        sclk_d <= sclk_s;
   end

   assign active = ~cs_s;
   assign rise   = active &  sclk_s & ~sclk_d;
   assign fall   = active & ~sclk_s &  sclk_d;

   spi_regport_engine u_engine (
      .clk(clk), .rst_n(rst_n), .active(active), .sclk_rise(rise), .sclk_fall(fall),
      .sdi(mosi_s), .rd_data(rd_data), .addr(addr), .wr_stb(wr_stb), .wr_data(wr_data),
      .cap_stb(cap_stb), .clr_stb(clr_stb), .sdo(sdo), .in_cnt(in_cnt), .out_cnt(out_cnt)
   );

   spi_regport_regs #(
      .N_CH(N_CH), .SCR_BYTES(SCR_BYTES), .SCR_BASE(SCR_BASE), .RSSI_BASE(RSSI_BASE),
      .TEMP_ADDR(TEMP_ADDR), .RXEN_ADDR(RXEN_ADDR), .TXEN_ADDR(TXEN_ADDR),
      .FAULT_ADDR(FAULT_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_stb(wr_stb), .wr_data(wr_data),
      .cap_stb(cap_stb), .clr_stb(clr_stb), .rssi_in(rssi_in), .temp_in(temp_in),
      .fault_in(tx_fault_in), .rd_data(rd_data), .rx_en(rx_chan_en), .tx_en(tx_chan_en),
      .fault_lat(fault_lat)
   );

   assign spi_miso    = sdo;
   assign spi_miso_oe = active;
endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk
   import spi_regport_pkg::*;
#(
   parameter int N_CH        = 4,
   parameter int SYNC_STAGES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_n,
   input logic             miso_oe,
   input logic             wr_stb,
   input logic             clr_stb,
   input logic [CNT_W-1:0] in_cnt,
   input logic [CNT_W-1:0] out_cnt,
   input logic [N_CH-1:0]  rx_en,
   input logic [N_CH-1:0]  tx_en,
   input logic [N_CH-1:0]  fault_in,
   input logic [N_CH-1:0]  fault_lat
);
   logic [3:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              hi_cnt <= '0;
      else if (!cs_n)          hi_cnt <= '0;
      else if (hi_cnt != 4'hF) hi_cnt <= hi_cnt + 1'b1;
   end

   // R5: output driver released once deselect has passed the synchronizer
   a_r5_oe_released: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(hi_cnt) > SYNC_STAGES) |-> !miso_oe);

   // R6: bit counters never run past one frame
   a_r6_frame_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(in_cnt) <= FRAME_BITS) && (int'(out_cnt) <= FRAME_BITS));

   // R11: latched clear only after the final input bit
   a_r11_clear_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      clr_stb |-> (int'(in_cnt) == FRAME_BITS));

   // R2: enable registers move only on a write strobe
   a_r2_enable_write_only: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(rx_en) || !$stable(tx_en)) |-> $past(wr_stb));

   // R10: any enabled live fault is latched on the next edge
   a_r10_latch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((fault_lat & $past(fault_in & tx_en)) == $past(fault_in & tx_en)));
endmodule

bind spi_regport spi_regport_chk #(.N_CH(N_CH), .SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .miso_oe(spi_miso_oe),
   .wr_stb(wr_stb), .clr_stb(clr_stb), .in_cnt(in_cnt), .out_cnt(out_cnt),
   .rx_en(rx_chan_en), .tx_en(tx_chan_en), .fault_in(tx_fault_in), .fault_lat(fault_lat)
);

// File: tb/spi_regport_bench.sv
`timescale 1ns/1ps
module spi_regport_bench;
   localparam int H = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b1, cs_n = 1'b1, mosi = 1'b0;
   logic        miso, miso_oe;
   logic [31:0] rssi = 32'h44332211;
   logic [7:0]  temp = 8'hE7;
   logic [3:0]  fault = 4'h0;
   logic [3:0]  rx_en, tx_en;
   int          n_tot = 0, n_bad = 0;
   bit          finished = 1'b0;

   always #2.5 clk = ~clk;

   spi_regport u_spi_regport (
      .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
      .spi_miso(miso), .spi_miso_oe(miso_oe), .rssi_in(rssi), .temp_in(temp),
      .tx_fault_in(fault), .rx_chan_en(rx_en), .tx_chan_en(tx_en)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_tot++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic xfer(input logic [7:0] b0, b1, b2, input int extra,
                       output logic [7:0] r0, r1, r2, output bit held);
      logic [23:0] tx = {b0, b1, b2};
      logic [23:0] rx = '0;
      held = 1'b1;
      cs_n = 1'b0;
      tick(H);
      for (int i = 23; i >= 0; i--) begin
         sclk = 1'b0; mosi = tx[i];
         tick(H);
         rx[i] = miso;
         sclk = 1'b1;
         tick(H);
      end
      for (int e = 0; e < extra; e++) begin
         sclk = 1'b0; mosi = 1'b1;
         tick(H);
         if (miso !== rx[0]) held = 1'b0;
         sclk = 1'b1;
         tick(H);
      end
      cs_n = 1'b1; mosi = 1'b0;
      tick(2*H);
      {r0, r1, r2} = rx;
   endtask

   task automatic do_wr(input logic [5:0] a, input logic [7:0] d);
      logic [7:0] r0, r1, r2; bit h;
      xfer({2'b00, a}, d, 8'h00, 0, r0, r1, r2, h);
      chk("R3", "write byte1", r0, 8'h00);
      chk("R3", "write echo cmd", r1, {2'b00, a});
      chk("R12", "write echo data", r2, d);
   endtask

   task automatic do_rd(input logic [5:0] a, output logic [7:0] d);
      logic [7:0] r0, r1, r2; bit h;
      xfer({2'b01, a}, 8'h00, 8'h00, 0, r0, r1, r2, h);
      chk("R3", "read echo cmd", r1, {2'b01, a});
      d = r2;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      chk("R5", "oe after reset", miso_oe, 1'b0);
      chk("R7", "rx port reset", rx_en, 4'hF);
      chk("R7", "tx port reset", tx_en, 4'hF);
      do_rd(6'h25, d); chk("R7", "rx reg reset", d, 8'h0F);
      do_rd(6'h34, d); chk("R7", "tx reg reset", d, 8'h0F);
      do_rd(6'h16, d); chk("R8", "scratch reset", d, 8'h00);
   endtask

   task automatic t_scratch();
      logic [7:0] d;
      do_wr(6'h14, 8'hA5);
      do_wr(6'h17, 8'h3C);
      do_rd(6'h14, d); chk("R2", "read scratch0", d, 8'hA5);
      do_rd(6'h17, d); chk("R8", "read scratch3", d, 8'h3C);
      do_rd(6'h15, d); chk("R8", "scratch1 untouched", d, 8'h00);
   endtask

   task automatic t_enables();
      logic [7:0] d;
      do_wr(6'h25, 8'hF6);
      chk("R2", "rx port after write", rx_en, 4'h6);
      do_rd(6'h25, d); chk("R7", "rx upper bits zero", d, 8'h06);
      do_wr(6'h34, 8'h09);
      chk("R2", "tx port after write", tx_en, 4'h9);
   endtask

   task automatic t_readonly();
      logic [7:0] d;
      do_rd(6'h20, d); chk("R9", "rssi ch0", d, 8'h11);
      do_rd(6'h23, d); chk("R9", "rssi ch3", d, 8'h44);
      do_rd(6'h24, d); chk("R9", "temperature", d, 8'hE7);
      do_wr(6'h20, 8'hFF);
      do_rd(6'h20, d); chk("R9", "rssi write discarded", d, 8'h11);
      do_wr(6'h3F, 8'h77);
      do_rd(6'h3F, d); chk("R9", "undefined reads zero", d, 8'h00);
   endtask

   task automatic t_noop();
      logic [7:0] r0, r1, r2, d; bit h;
      xfer(8'h94, 8'h11, 8'h00, 0, r0, r1, r2, h);
      chk("R3", "nop echo cmd", r1, 8'h94);
      chk("R3", "nop echo data", r2, 8'h11);
      do_rd(6'h14, d); chk("R4", "nop 0x80 no write", d, 8'hA5);
      xfer(8'hE5, 8'h00, 8'h00, 0, r0, r1, r2, h);
      chk("R4", "nop 0xC0 rx port kept", rx_en, 4'h6);
      do_rd(6'h25, d); chk("R4", "nop 0xC0 rx reg kept", d, 8'h06);
   endtask

   task automatic t_deselect();
      logic [7:0] d;
      int bad = 0;
      for (int i = 0; i < 24; i++) begin
         sclk = 1'b0; mosi = i[0];
         tick(H);
         if (miso_oe !== 1'b0) bad++;
         sclk = 1'b1;
         tick(H);
      end
      mosi = 1'b0;
      chk("R5", "oe low while deselected", bad, 0);
      do_rd(6'h14, d); chk("R5", "deselected activity ignored", d, 8'hA5);
   endtask

   task automatic t_extra();
      logic [7:0] r0, r1, r2, d; bit h;
      xfer(8'h15, 8'h81, 8'h00, 8, r0, r1, r2, h);
      chk("R6", "last bit held", h, 1'b1);
      chk("R6", "echo data with extra clocks", r2, 8'h81);
      do_rd(6'h15, d); chk("R6", "write kept", d, 8'h81);
      do_rd(6'h16, d); chk("R6", "extra clocks no new op", d, 8'h00);
   endtask

   task automatic t_fault();
      logic [7:0] d, r0, r1, r2; bit h;
      do_wr(6'h34, 8'h0F);
      fault = 4'b0101; tick(5); fault = 4'h0; tick(2);
      do_rd(6'h36, d); chk("R10", "latched pulse", d, 8'h50);
      do_rd(6'h36, d); chk("R11", "cleared by read", d, 8'h00);
      do_wr(6'h34, 8'h03);
      fault = 4'b1100; tick(5); fault = 4'h0; tick(2);
      do_rd(6'h36, d); chk("R10", "disabled channel masked", d, 8'h00);
      do_wr(6'h34, 8'h0F);
      fault = 4'b0001; tick(3);
      do_rd(6'h36, d); chk("R10", "live and latched", d, 8'h11);
      do_rd(6'h36, d); chk("R11", "live fault wins clear", d, 8'h11);
      fault = 4'h0; tick(2);
      do_rd(6'h36, d); chk("R11", "latched after live drop", d, 8'h10);
      do_rd(6'h36, d); chk("R11", "clear after drop", d, 8'h00);
      fork
         xfer(8'h76, 8'h00, 8'h00, 0, r0, r1, r2, h);
         begin
            tick(H + 40*H);
            fault = 4'b0100; tick(3); fault = 4'h0;
         end
      join
      chk("R11", "read before late fault", r2, 8'h00);
      do_rd(6'h36, d); chk("R11", "late fault not cleared", d, 8'h40);
      do_rd(6'h36, d); chk("R11", "late fault cleared next", d, 8'h00);
   endtask

   initial begin
      tick(5);
      rst_n = 1'b1;
      tick(5);
      t_reset();
      t_scratch();
      t_enables();
      t_readonly();
      t_noop();
      t_deselect();
      t_extra();
      t_fault();
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_tot++; n_bad++;
         $display("FAIL R1 watchdog: actual=timeout expected=done");
         $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
         $finish;
      end
   end
endmodule